// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block compares two square-wave edge streams: a reference stream and a divided oscillator stream. Both arrive asynchronously and are resampled on a faster system clock. A rising edge on either stream arms a direction flag for that stream. When both flags are armed, both are held for a programmable minimum width and then released together. Because every comparison cycle ends with this shared pulse, the detector has no dead zone around phase coincidence.

The error signal is available in two forms. The first is a single-ended output with a separate enable. It is driven high when the reference is ahead, driven low when the oscillator is ahead, and left floating when the two are coincident. The second is a pair of active-low outputs, one per direction, which an external combiner can merge. A lock flag stays high while the loop is aligned and drops whenever one direction alone stays armed longer than the minimum window.

Top module: `phase_freq_detector`

## Requirements
- R1: While `rst_ni` is low and after its release with no input edges, `phr_n_o` and `phv_n_o` are 1, `pd_oe_o` is 0 and `lock_o` is 1.
- R2: A reference rising edge with the oscillator flag clear drives `phr_n_o` to 0 and `pd_oe_o` to 1 with `pd_o` = 1, while `phv_n_o` stays 1.
- R3: An oscillator rising edge with the reference flag clear drives `phv_n_o` to 0 and `pd_oe_o` to 1 with `pd_o` = 0, while `phr_n_o` stays 1.
- R4: Once both flags are armed, `phr_n_o` and `phv_n_o` are both 0 for exactly `min_pw_i` clock cycles and then both return to 1. `pd_oe_o` is 0 in all of those cycles.
- R5: A `min_pw_i` value of 0 behaves as 1. The valid window range is 1 to 15 cycles.
- R6: `lock_o` is 0 in exactly those cycles in which one flag alone has already been armed for at least `min_pw_i` prior cycles. Otherwise it is 1.
- R7: A further rising edge, or any falling edge, on a stream whose flag is already armed causes no extra output. The armed flag persists until the other stream's edge arrives.
- R8: An input transition applied just after a clock edge shows on the outputs after the third following rising clock edge. This latency comes from two synchronizer stages plus the edge register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than both input streams |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference square wave, asynchronous |
| vco_i | input | 1 | Divided oscillator square wave, asynchronous |
| min_pw_i | input | 4 | Minimum coincident pulse width in clocks (0 acts as 1) |
| pd_o | output | 1 | Single-ended error drive value |
| pd_oe_o | output | 1 | Enable for `pd_o`; 0 means high impedance |
| phr_n_o | output | 1 | Active-low error output, reference-ahead direction |
| phv_n_o | output | 1 | Active-low error output, oscillator-ahead direction |
| lock_o | output | 1 | Lock flag, low while out of lock |

## Verification
The hardest case to reach from the ports is an absorbed edge. Here a stream toggles again while its flag is still armed, and the output must show neither a second pulse nor an early release. The bench reaches this case by holding the oscillator input quiet while the reference falls and rises once more, and only then raising the oscillator. It then checks three things: the total low time on the reference-direction output, the lock-low count, and a quiet tail afterwards. The exact coincident window is reached by raising both inputs on the same clock phase, so that both flags arm on the same edge. The pulse length is then counted at the widths 0, 4 and 15.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned PW_W_DEF = 4;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10,
    DIR_BOTH = 2'b11
  } pfd_dir_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core #(
  parameter int unsigned PW_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_ref_i,
  input  logic            rise_vco_i,
  input  logic [PW_W-1:0] min_pw_i,
  output pfd_pkg::pfd_dir_e dir_o
);
  import pfd_pkg::*;

  logic            up_q, dn_q;
  logic [PW_W-1:0] hold_q;
  logic [PW_W-1:0] eff_pw;
  logic            both, clr;

  assign eff_pw = (min_pw_i == '0) ? PW_W'(1) : min_pw_i;
  assign both   = up_q & dn_q;
  assign clr    = both && (hold_q == eff_pw - PW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      // an edge landing on the release cycle re-arms its flag
      up_q   <= clr ? rise_ref_i : (up_q | rise_ref_i);
      dn_q   <= clr ? rise_vco_i : (dn_q | rise_vco_i);
      hold_q <= (both && !clr) ? hold_q + PW_W'(1) : '0;
    end
  end

  assign dir_o = pfd_dir_e'({dn_q, up_q});
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned PW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pfd_pkg::pfd_dir_e dir_i,
  input  logic [PW_W-1:0]   min_pw_i,
  output logic              lock_o
);
  import pfd_pkg::*;
  localparam int unsigned CW = PW_W + 1;

  logic [CW-1:0] span_q;
  logic [CW-1:0] eff_pw;
  logic          single;

  assign eff_pw = (min_pw_i == '0) ? CW'(1) : {1'b0, min_pw_i};
  assign single = (dir_i == DIR_UP) || (dir_i == DIR_DN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               span_q <= '0;
    else if (!single)          span_q <= '0;
    else if (span_q != '1)     span_q <= span_q + CW'(1);
  end

  assign lock_o = !(single && (span_q >= eff_pw));
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PW_W        = pfd_pkg::PW_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic            vco_i,
  input  logic [PW_W-1:0] min_pw_i,
  output logic            pd_o,
  output logic            pd_oe_o,
  output logic            phr_n_o,
  output logic            phv_n_o,
  output logic            lock_o
);
  import pfd_pkg::*;
  localparam int unsigned NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise;
  pfd_dir_e       dir;

  assign raw_in = {vco_i, ref_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_in[c]),
      .rise_o (rise[c])
    );
  end

  pfd_state_core #(.PW_W(PW_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_ref_i(rise[0]),
    .rise_vco_i(rise[1]),
    .min_pw_i  (min_pw_i),
    .dir_o     (dir)
  );

  pfd_lock_mon #(.PW_W(PW_W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_i   (dir),
    .min_pw_i(min_pw_i),
    .lock_o  (lock_o)
  );

  always_comb begin
    phr_n_o = 1'b1;
    phv_n_o = 1'b1;
    pd_o    = 1'b0;
    pd_oe_o = 1'b0;
    unique case (dir)
      DIR_UP:   begin phr_n_o = 1'b0; pd_o = 1'b1; pd_oe_o = 1'b1; end
      DIR_DN:   begin phv_n_o = 1'b0; pd_o = 1'b0; pd_oe_o = 1'b1; end
      DIR_BOTH: begin phr_n_o = 1'b0; phv_n_o = 1'b0; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int unsigned PW_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PW_W-1:0] min_pw_i,
  input logic            pd_o,
  input logic            pd_oe_o,
  input logic            phr_n_o,
  input logic            phv_n_o,
  input logic            lock_o
);
  localparam int unsigned CW = PW_W + 1;

  logic          both_low;
  logic [CW-1:0] low_run_q;
  logic [CW-1:0] eff_pw;

  assign both_low = !phr_n_o && !phv_n_o;
  assign eff_pw   = (min_pw_i == '0) ? CW'(1) : {1'b0, min_pw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_run_q <= '0;
    else if (both_low && low_run_q != '1) low_run_q <= low_run_q + CW'(1);
    else if (!both_low)                   low_run_q <= '0;
  end

  AST_OE_ONE_SIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_oe_o |-> (phr_n_o != phv_n_o)); // R2
  AST_PD_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_oe_o |-> (pd_o == phv_n_o)); // R3
  AST_FLOAT_AT_COINCIDENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_low |-> !pd_oe_o); // R4
  AST_PULSE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_low |-> (low_run_q < eff_pw)); // R5
  AST_LOCK_ONLY_ONE_SIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (phr_n_o ^ phv_n_o)); // R6
endmodule

bind phase_freq_detector pfd_checker #(.PW_W(PW_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .min_pw_i(min_pw_i),
  .pd_o    (pd_o),
  .pd_oe_o (pd_oe_o),
  .phr_n_o (phr_n_o),
  .phv_n_o (phv_n_o),
  .lock_o  (lock_o)
);

// File: tb/phase_freq_detector_tb.sv
module phase_freq_detector_tb;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       vco_in = 1'b0;
  logic [3:0] min_pw = 4'd1;
  logic       pd, pd_oe, phr_n, phv_n, lock;

  int n_chk = 0;
  int n_bad = 0;

  logic mon_en = 1'b0;
  int c_phr, c_phv, c_both, c_up_drv, c_dn_drv, c_oe_both, c_lock_low, c_tail_err;
  int tail_start, cyc;

  always #(CLK_P/2) clk = ~clk;

  phase_freq_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_in), .vco_i(vco_in),
    .min_pw_i(min_pw), .pd_o(pd), .pd_oe_o(pd_oe),
    .phr_n_o(phr_n), .phv_n_o(phv_n), .lock_o(lock)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (!phr_n) c_phr++;
      if (!phv_n) c_phv++;
      if (!phr_n && !phv_n) c_both++;
      if (pd_oe && pd)  c_up_drv++;
      if (pd_oe && !pd) c_dn_drv++;
      if (pd_oe && !phr_n && !phv_n) c_oe_both++;
      if (!lock) c_lock_low++;
      if (cyc > tail_start && (!phr_n || !phv_n || pd_oe || !lock)) c_tail_err++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_start(input int tail);
    c_phr = 0; c_phv = 0; c_both = 0; c_up_drv = 0; c_dn_drv = 0;
    c_oe_both = 0; c_lock_low = 0; c_tail_err = 0; cyc = 0;
    tail_start = tail;
    mon_en = 1'b1;
  endtask

  task automatic finish_window();
    ref_in = 1'b0; vco_in = 1'b0;
    repeat (40) @(negedge clk);
    mon_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(phr_n == 1'b1 && phv_n == 1'b1, "R1 dual idle", {phr_n, phv_n}, 3);
    check(pd_oe == 1'b0, "R1 float", pd_oe, 0);
    check(lock == 1'b1, "R1 lock", lock, 1);
  endtask

  task automatic t_latency();
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk); check(phr_n == 1'b1, "R8 after 1 edge", phr_n, 1);
    @(negedge clk); check(phr_n == 1'b1, "R8 after 2 edges", phr_n, 1);
    @(negedge clk); check(phr_n == 1'b0, "R8 after 3 edges", phr_n, 0);
    vco_in = 1'b1;
    repeat (3) @(negedge clk);
    finish_window();
  endtask

  task automatic t_coincident(input logic [3:0] pw, input int exp_w, input string req);
    min_pw = pw;
    @(negedge clk);
    mon_start(36);
    ref_in = 1'b1; vco_in = 1'b1;
    repeat (4) @(negedge clk);
    finish_window();
    check(c_both == exp_w, req, c_both, exp_w);
    check(c_phr == exp_w && c_phv == exp_w, {req, " simultaneous"}, c_phr - c_phv, 0);
    check(c_up_drv + c_dn_drv == 0, "R4 no drive at coincidence", c_up_drv + c_dn_drv, 0);
    check(c_lock_low == 0, "R6 lock held when aligned", c_lock_low, 0);
  endtask

  task automatic t_ref_ahead();
    min_pw = 4'd3;
    @(negedge clk);
    mon_start(40);
    ref_in = 1'b1;
    repeat (6) @(negedge clk);
    vco_in = 1'b1;
    repeat (3) @(negedge clk);
    finish_window();
    check(c_phr == 9, "R2 ref-direction low time", c_phr, 9);
    check(c_phv == 3, "R2 other stays high except window", c_phv, 3);
    check(c_up_drv == 6 && c_dn_drv == 0, "R2 drive high count", c_up_drv, 6);
    check(c_oe_both == 0, "R4 float while both low", c_oe_both, 0);
    check(c_lock_low == 3, "R6 lock low cycles ref ahead", c_lock_low, 3);
  endtask

  task automatic t_vco_ahead();
    min_pw = 4'd2;
    @(negedge clk);
    mon_start(40);
    vco_in = 1'b1;
    repeat (5) @(negedge clk);
    ref_in = 1'b1;
    repeat (3) @(negedge clk);
    finish_window();
    check(c_phv == 7, "R3 vco-direction low time", c_phv, 7);
    check(c_phr == 2, "R3 other stays high except window", c_phr, 2);
    check(c_dn_drv == 5 && c_up_drv == 0, "R3 drive low count", c_dn_drv, 5);
    check(c_lock_low == 3, "R6 lock low cycles vco ahead", c_lock_low, 3);
  endtask

  task automatic t_absorbed();
    min_pw = 4'd2;
    @(negedge clk);
    mon_start(24);
    ref_in = 1'b1;
    repeat (2) @(negedge clk); ref_in = 1'b0;
    repeat (2) @(negedge clk); ref_in = 1'b1;
    repeat (4) @(negedge clk); vco_in = 1'b1;
    repeat (3) @(negedge clk);
    finish_window();
    check(c_phr == 10, "R7 repeat edge absorbed", c_phr, 10);
    check(c_phv == 2, "R7 release only by other stream", c_phv, 2);
    check(c_lock_low == 6, "R6 lock low through absorbed edge", c_lock_low, 6);
    check(c_tail_err == 0, "R7 no trailing output", c_tail_err, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_latency();
    t_coincident(4'd4,  4,  "R4 window width 4");
    t_coincident(4'd0,  1,  "R5 width 0 acts as 1");
    t_coincident(4'd15, 15, "R5 width 15");
    t_ref_ahead();
    t_vco_ahead();
    t_absorbed();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule